// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block copies a programmed number of bytes between a word-wide memory port and a card data path by walking a linked list of four-word descriptors held in memory. Each descriptor carries a status word, a buffer size, a buffer address and a pointer to the next descriptor. After a start pulse the engine fetches the descriptor at the programmed base address, moves up to one buffer of data in the chosen direction, writes the descriptor's status word back with its ownership bit cleared, and then either follows the next pointer or finishes.

Data flows from memory to an outgoing valid/ready stream when the write direction is selected, and from an incoming valid/ready stream into memory otherwise. On completion the engine raises a set of sticky completion flags that hold until the next accepted start, and reports the remaining transfer count.

Top module: `sg_desc_dma`

## Requirements
- R1: A start pulse is ignored (no memory request, no done pulse, flags and remaining count unchanged) when the byte count is 0, the block size is 0, `dma_en` is low, or the direction is read (`dir_write`=0) and `card_data_rdy` is low.
- R2: A descriptor is fetched with four word reads at its address +0, +4, +8, +12, in that order: status, size, buffer address, next pointer.
- R3: A size word of 0 is taken as `MAX_BUF_BYTES`; a size word above `MAX_BUF_BYTES` is clamped to `MAX_BUF_BYTES`.
- R4: The bytes moved for one descriptor are the smaller of its effective size and the remaining count, carried as ceil(bytes/4) word transfers.
- R5: The buffer address has its two low bits forced to zero, and successive words of a buffer go to successive word addresses.
- R6: After a descriptor's data is moved, its status word is written back to the descriptor address with bit 31 (hold) cleared and all other bits unchanged.
- R7: The engine finishes after a descriptor whose status bit 2 (last) is set, or when the remaining count reaches zero; otherwise it fetches the descriptor at the next pointer.
- R8: With `dir_write`=1 each buffer word is read from memory and sent on `tx_data`; with `dir_write`=0 each word taken from `rx_data` is written to memory.
- R9: On finishing, `done` pulses for one cycle and `data_complete`, `sdio_irq`, `dma_summary` are set, plus `tx_done` for a write or `rx_done` for a read; all five flags are cleared by the next accepted start and are 0 after reset.
- R10: `remaining` is loaded with the byte count at start and reduced by the bytes moved for each descriptor, saturating at zero; it never rises during a transfer.
- R11: A memory request holds its address, direction and write data until acknowledged, each access is performed exactly once, and `tx_valid` holds `tx_data` until `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse |
| dma_en | input | 1 | DMA enable |
| dir_write | input | 1 | 1: memory to card, 0: card to memory |
| card_data_rdy | input | 1 | Card has read data available |
| byte_count | input | 32 | Total bytes to move |
| block_size | input | 32 | Card block size, must be non-zero |
| desc_base | input | 32 | Address of the first descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory acknowledge |
| tx_valid | output | 1 | Outgoing word valid |
| tx_ready | input | 1 | Outgoing word accepted |
| tx_data | output | 32 | Outgoing word |
| rx_valid | input | 1 | Incoming word valid |
| rx_ready | output | 1 | Incoming word accepted |
| rx_data | input | 32 | Incoming word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| remaining | output | 32 | Remaining byte count |
| data_complete | output | 1 | Data-complete flag |
| sdio_irq | output | 1 | Card interrupt flag |
| dma_summary | output | 1 | DMA summary flag |
| tx_done | output | 1 | Write-direction completion flag |
| rx_done | output | 1 | Read-direction completion flag |

## Verification
The hardest situation to reach is a descriptor whose size field has to be clamped while the count, not the last flag, ends the chain inside a later descriptor. The bench instantiates the engine with a small maximum buffer size so that an oversize first descriptor and a zero-size second descriptor both clamp within a short run, and it places a garbage next pointer after a descriptor without the last flag so that an extra fetch would show up in the access log. A memory model that alternates one-cycle and two-cycle acknowledges and a sink that toggles its ready flag exercise the hold rules on both ports.

// File: rtl/sgd_pkg.sv
// Shared constants and types for the chained descriptor DMA engine.
// Assumes 32-bit descriptor words and 32-bit memory and stream data.
package sgd_pkg;
    localparam int WORD_W   = 32;
    localparam int DESC_WORDS = 4;

    // Status word bit positions (decoded by software that owns the list)
    localparam int ST_HOLD  = 31;
    localparam int ST_ERR   = 30;
    localparam int ST_CHAIN = 4;
    localparam int ST_FIRST = 3;
    localparam int ST_LAST  = 2;
    localparam int ST_NOIRQ = 1;

    // Descriptor word indices
    localparam int DW_STATUS = 0;
    localparam int DW_SIZE   = 1;
    localparam int DW_BUF    = 2;
    localparam int DW_NEXT   = 3;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_SETUP,
        S_MEMRD,
        S_TXPUSH,
        S_RXPOP,
        S_MEMWR,
        S_WBACK,
        S_NEXT
    } sgd_state_t;
endpackage

// File: rtl/sgd_chunk_calc.sv
// Computes the bytes and word transfers for one descriptor.
// Assumes remaining is non-zero whenever the result is used.
module sgd_chunk_calc
    import sgd_pkg::*;
#(
    parameter int MAX_BUF_BYTES = 8192
) (
    input  logic [WORD_W-1:0] size_field,
    input  logic [WORD_W-1:0] remaining,
    output logic [WORD_W-1:0] chunk_bytes,
    output logic [WORD_W-1:0] chunk_words
);
    localparam logic [WORD_W-1:0] MAX_V = WORD_W'(MAX_BUF_BYTES);

    logic [WORD_W-1:0] eff_size;

    // Clamp: zero or oversize maps to the maximum buffer size
    always_comb begin
        if (size_field == '0 || size_field > MAX_V)
            eff_size = MAX_V;
        else
            eff_size = size_field;
    end

    // Smaller of effective size and remaining count, then round up to words
    always_comb begin
        chunk_bytes = (eff_size < remaining) ? eff_size : remaining;
        chunk_words = (chunk_bytes + WORD_W'(3)) >> 2;
    end
endmodule

// File: rtl/sgd_remaining.sv
// Remaining byte counter: loads at start, subtracts per descriptor and
// saturates at zero. Assumes load and dec are never high together.
module sgd_remaining
    import sgd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              dec,
    input  logic [WORD_W-1:0] dec_val,
    output logic [WORD_W-1:0] count,
    output logic              is_zero
);
    // Count register with saturating decrement
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (dec)
            count <= (count > dec_val) ? (count - dec_val) : '0;
    end

    // Zero indication for the sequencer
    always_comb is_zero = (count == '0);
endmodule

// File: rtl/sg_desc_dma.sv
// Chained descriptor DMA engine. Fetches a descriptor, moves one buffer
// between memory and the card streams, writes the status back with the
// hold bit cleared and follows the chain until the last flag or a zero
// remaining count. Assumes a single-outstanding request/ack memory port
// with read data valid in the ack cycle.
module sg_desc_dma
    import sgd_pkg::*;
#(
    parameter int MAX_BUF_BYTES = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dma_en,
    input  logic              dir_write,
    input  logic              card_data_rdy,
    input  logic [WORD_W-1:0] byte_count,
    input  logic [WORD_W-1:0] block_size,
    input  logic [WORD_W-1:0] desc_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [WORD_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [WORD_W-1:0] rx_data,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] remaining,
    output logic              data_complete,
    output logic              sdio_irq,
    output logic              dma_summary,
    output logic              tx_done,
    output logic              rx_done
);
    localparam logic [WORD_W-1:0] WORD_BYTES = WORD_W'(WORD_W / 8);
    localparam logic [WORD_W-1:0] HOLD_MASK  = ~(WORD_W'(1) << ST_HOLD);

    sgd_state_t        state;
    logic [WORD_W-1:0] dword [DESC_WORDS];
    logic [1:0]        fetch_idx;
    logic [WORD_W-1:0] cur_desc;
    logic [WORD_W-1:0] buf_base;
    logic [WORD_W-1:0] offset;
    logic [WORD_W-1:0] words_left;
    logic [WORD_W-1:0] chunk_r;
    logic              xfer_wr;

    logic              start_ok;
    logic              accept;
    logic [WORD_W-1:0] chunk_bytes;
    logic [WORD_W-1:0] chunk_words;
    logic              rem_zero;
    logic              rem_dec;
    logic              data_phase;
    logic              wb_phase;

    // Start gating: all preconditions for a transfer
    always_comb begin
        start_ok = (byte_count != '0) && (block_size != '0) && dma_en
                   && (dir_write || card_data_rdy);
        accept   = (state == S_IDLE) && start && start_ok;
    end

    // Phase indications used by the sequencer outputs and the checker
    always_comb begin
        busy       = (state != S_IDLE);
        rx_ready   = (state == S_RXPOP);
        data_phase = (state == S_MEMRD) || (state == S_MEMWR);
        wb_phase   = (state == S_WBACK);
        rem_dec    = wb_phase && mem_ack;
    end

    sgd_chunk_calc #(.MAX_BUF_BYTES(MAX_BUF_BYTES)) u_chunk (
        .size_field (dword[DW_SIZE]),
        .remaining  (remaining),
        .chunk_bytes(chunk_bytes),
        .chunk_words(chunk_words)
    );

    sgd_remaining u_rem (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .load_val(byte_count),
        .dec     (rem_dec),
        .dec_val (chunk_r),
        .count   (remaining),
        .is_zero (rem_zero)
    );

    // Descriptor word capture during fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DESC_WORDS; i++) dword[i] <= '0;
        end else if (state == S_FETCH && mem_ack) begin
            dword[fetch_idx] <= mem_rdata;
        end
    end

    // Main sequencer: fetch, move, write back, chain, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= S_IDLE;
            fetch_idx     <= '0;
            cur_desc      <= '0;
            buf_base      <= '0;
            offset        <= '0;
            words_left    <= '0;
            chunk_r       <= '0;
            xfer_wr       <= 1'b0;
            mem_req       <= 1'b0;
            mem_we        <= 1'b0;
            mem_addr      <= '0;
            mem_wdata     <= '0;
            tx_valid      <= 1'b0;
            tx_data       <= '0;
            done          <= 1'b0;
            data_complete <= 1'b0;
            sdio_irq      <= 1'b0;
            dma_summary   <= 1'b0;
            tx_done       <= 1'b0;
            rx_done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        cur_desc      <= desc_base;
                        xfer_wr       <= dir_write;
                        data_complete <= 1'b0;
                        sdio_irq      <= 1'b0;
                        dma_summary   <= 1'b0;
                        tx_done       <= 1'b0;
                        rx_done       <= 1'b0;
                        fetch_idx     <= '0;
                        mem_req       <= 1'b1;
                        mem_we        <= 1'b0;
                        mem_addr      <= desc_base;
                        state         <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (mem_ack) begin
                        if (fetch_idx == 2'd3) begin
                            mem_req <= 1'b0;
                            state   <= S_SETUP;
                        end else begin
                            fetch_idx <= fetch_idx + 2'd1;
                            mem_addr  <= mem_addr + WORD_BYTES;
                        end
                    end
                end
                S_SETUP: begin
                    chunk_r    <= chunk_bytes;
                    words_left <= chunk_words;
                    offset     <= '0;
                    buf_base   <= {dword[DW_BUF][WORD_W-1:2], 2'b00};
                    if (xfer_wr) begin
                        mem_req  <= 1'b1;
                        mem_we   <= 1'b0;
                        mem_addr <= {dword[DW_BUF][WORD_W-1:2], 2'b00};
                        state    <= S_MEMRD;
                    end else begin
                        state <= S_RXPOP;
                    end
                end
                S_MEMRD: begin
                    if (mem_ack) begin
                        mem_req  <= 1'b0;
                        tx_valid <= 1'b1;
                        tx_data  <= mem_rdata;
                        state    <= S_TXPUSH;
                    end
                end
                S_TXPUSH: begin
                    if (tx_ready) begin
                        tx_valid   <= 1'b0;
                        words_left <= words_left - WORD_W'(1);
                        offset     <= offset + WORD_BYTES;
                        if (words_left == WORD_W'(1)) begin
                            mem_req   <= 1'b1;
                            mem_we    <= 1'b1;
                            mem_addr  <= cur_desc;
                            mem_wdata <= dword[DW_STATUS] & HOLD_MASK;
                            state     <= S_WBACK;
                        end else begin
                            mem_req  <= 1'b1;
                            mem_we   <= 1'b0;
                            mem_addr <= buf_base + offset + WORD_BYTES;
                            state    <= S_MEMRD;
                        end
                    end
                end
                S_RXPOP: begin
                    if (rx_valid) begin
                        mem_req   <= 1'b1;
                        mem_we    <= 1'b1;
                        mem_addr  <= buf_base + offset;
                        mem_wdata <= rx_data;
                        state     <= S_MEMWR;
                    end
                end
                S_MEMWR: begin
                    if (mem_ack) begin
                        words_left <= words_left - WORD_W'(1);
                        offset     <= offset + WORD_BYTES;
                        if (words_left == WORD_W'(1)) begin
                            mem_addr  <= cur_desc;
                            mem_wdata <= dword[DW_STATUS] & HOLD_MASK;
                            state     <= S_WBACK;
                        end else begin
                            mem_req <= 1'b0;
                            mem_we  <= 1'b0;
                            state   <= S_RXPOP;
                        end
                    end
                end
                S_WBACK: begin
                    if (mem_ack) begin
                        mem_req <= 1'b0;
                        mem_we  <= 1'b0;
                        state   <= S_NEXT;
                    end
                end
                S_NEXT: begin
                    if (rem_zero) data_complete <= 1'b1;
                    if (dword[DW_STATUS][ST_LAST] || rem_zero) begin
                        done          <= 1'b1;
                        data_complete <= 1'b1;
                        sdio_irq      <= 1'b1;
                        dma_summary   <= 1'b1;
                        tx_done       <= xfer_wr;
                        rx_done       <= ~xfer_wr;
                        state         <= S_IDLE;
                    end else begin
                        cur_desc  <= dword[DW_NEXT];
                        fetch_idx <= '0;
                        mem_req   <= 1'b1;
                        mem_we    <= 1'b0;
                        mem_addr  <= dword[DW_NEXT];
                        state     <= S_FETCH;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sgd_dma_checker.sv
// Protocol and invariant checks for the chained descriptor DMA engine,
// attached to every instance of the top module by the bind below.
module sgd_dma_checker
    import sgd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [WORD_W-1:0] tx_data,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] remaining,
    input logic              data_complete,
    input logic              dma_summary,
    input logic              tx_done,
    input logic              rx_done,
    input logic              data_phase,
    input logic              wb_phase
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_buf_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && mem_req) |-> (mem_addr[1:0] == 2'b00));

    assert_wb_hold_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_phase && mem_req) |-> (mem_we && !mem_wdata[ST_HOLD]));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_done_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dma_summary && data_complete && $onehot0({tx_done, rx_done})));

    assert_dir_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && rx_done));

    assert_rem_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (remaining <= $past(remaining)));
endmodule

bind sg_desc_dma sgd_dma_checker u_sgd_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .busy         (busy),
    .done         (done),
    .remaining    (remaining),
    .data_complete(data_complete),
    .dma_summary  (dma_summary),
    .tx_done      (tx_done),
    .rx_done      (rx_done),
    .data_phase   (data_phase),
    .wb_phase     (wb_phase)
);

// File: tb/sg_desc_dma_test.sv
// Directed bench for the chained descriptor DMA engine: a word memory
// with alternating latency, a toggling outgoing sink and a counting
// incoming source. The engine runs with a 32-byte maximum buffer.
module sg_desc_dma_test;
    localparam int MAXB = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, dma_en = 1'b0, dir_write = 1'b0, card_data_rdy = 1'b0;
    logic [31:0] byte_count = '0, block_size = '0, desc_base = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_ready, rx_valid, rx_ready;
    logic [31:0] tx_data, rx_data;
    logic        busy, done, data_complete, sdio_irq, dma_summary, tx_done, rx_done;
    logic [31:0] remaining;

    always #10 clk = ~clk;

    sg_desc_dma #(.MAX_BUF_BYTES(MAXB)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dma_en(dma_en),
        .dir_write(dir_write), .card_data_rdy(card_data_rdy),
        .byte_count(byte_count), .block_size(block_size), .desc_base(desc_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .busy(busy), .done(done), .remaining(remaining),
        .data_complete(data_complete), .sdio_irq(sdio_irq),
        .dma_summary(dma_summary), .tx_done(tx_done), .rx_done(rx_done)
    );

    // Memory model, access log and bench preload port
    logic [31:0] mem [1024];
    logic [31:0] log_addr [1024];
    logic        log_we [1024];
    int          log_n = 0;
    logic        slow = 1'b0, stall = 1'b0;
    logic        bw_en = 1'b0;
    logic [31:0] bw_addr = '0, bw_data = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; slow <= 1'b0; stall <= 1'b0; mem_rdata <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (bw_en) mem[bw_addr[11:2]] <= bw_data;
            if (mem_req && !mem_ack) begin
                if (slow && !stall) stall <= 1'b1;
                else begin
                    mem_ack <= 1'b1; stall <= 1'b0; slow <= ~slow;
                    if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
                    else mem_rdata <= mem[mem_addr[11:2]];
                    log_addr[log_n] <= mem_addr;
                    log_we[log_n]   <= mem_we;
                    log_n <= log_n + 1;
                end
            end
        end
    end

    // Outgoing sink with toggling ready, incoming counting source
    logic [31:0] tx_log [1024];
    int          tx_n = 0;
    int          rx_seq = 0;
    int          done_cnt = 0;
    assign rx_valid = 1'b1;
    assign rx_data  = 32'hC0DE_0000 + rx_seq;

    always @(posedge clk) begin
        if (!rst_n) tx_ready <= 1'b0;
        else tx_ready <= ~tx_ready;
        if (tx_valid && tx_ready) begin
            tx_log[tx_n] <= tx_data;
            tx_n <= tx_n + 1;
        end
        if (rx_valid && rx_ready) rx_seq <= rx_seq + 1;
        if (done) done_cnt <= done_cnt + 1;
    end

    int n_checks = 0, n_fail = 0, cycles = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000", cycles);
            summary();
        end
    end

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); bw_en = 1'b1; bw_addr = a; bw_data = d;
        @(negedge clk); bw_en = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] st,
                            input logic [31:0] sz, input logic [31:0] bufa,
                            input logic [31:0] nxt);
        poke(a, st); poke(a + 4, sz); poke(a + 8, bufa); poke(a + 12, nxt);
    endtask

    task automatic kick(input logic wr, input logic [31:0] cnt, input logic [31:0] base);
        @(negedge clk);
        dir_write = wr; byte_count = cnt; desc_base = base;
        dma_en = 1'b1; block_size = 32'd512; card_data_rdy = 1'b1;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        for (int i = 0; i < 4000; i++) begin
            if (done_cnt != d0) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic check_fetch(input string req, input int l, input logic [31:0] base);
        for (int k = 0; k < 4; k++) begin
            check(req, log_addr[l + k], base + 32'(4 * k));
            check(req, 32'(log_we[l + k]), 32'd0);
        end
    endtask

    // Reset state
    task automatic t_reset();
        @(negedge clk);
        check("R9 reset busy", 32'(busy), 0);
        check("R9 reset flags", {27'd0, data_complete, sdio_irq, dma_summary, tx_done, rx_done}, 0);
        check("R10 reset remaining", remaining, 0);
        check("R11 reset req", 32'(mem_req), 0);
    endtask

    // R1: each gating condition blocks the start
    task automatic t_gate();
        for (int c = 0; c < 4; c++) begin
            int l0 = log_n, d0 = done_cnt;
            @(negedge clk);
            dir_write = (c != 3); card_data_rdy = 1'b0; dma_en = (c != 2);
            byte_count = (c == 0) ? 0 : 16; block_size = (c == 1) ? 0 : 512;
            desc_base = 32'h100; start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (10) @(negedge clk);
            check("R1 gated busy", 32'(busy), 0);
            check("R1 gated mem accesses", 32'(log_n - l0), 0);
            check("R1 gated done", 32'(done_cnt - d0), 0);
            check("R1 gated remaining", remaining, 0);
            check("R1 gated flags", {27'd0, data_complete, sdio_irq, dma_summary, tx_done, rx_done}, 0);
        end
    endtask

    // Single descriptor, memory to card
    task automatic t_write_single();
        int l0, t0, d0;
        put_desc(32'h100, 32'h8000_000C, 32'd16, 32'h400, 32'h0);
        for (int i = 0; i < 4; i++) poke(32'h400 + 32'(4 * i), 32'h1111_0000 + 32'(i));
        l0 = log_n; t0 = tx_n; d0 = done_cnt;
        kick(1'b1, 32'd16, 32'h100);
        wait_done(d0);
        check_fetch("R2 fetch order", l0, 32'h100);
        check("R8 tx count", 32'(tx_n - t0), 4);
        for (int i = 0; i < 4; i++) check("R8 tx data", tx_log[t0 + i], 32'h1111_0000 + 32'(i));
        check("R6 writeback", mem[32'h100 >> 2], 32'h0000_000C);
        check("R11 single access each", 32'(log_n - l0), 9);
        check("R10 remaining", remaining, 0);
        check("R9 flags write", {27'd0, data_complete, sdio_irq, dma_summary, tx_done, rx_done}, 32'b11110);
        check("R9 done once", 32'(done_cnt - d0), 1);
    endtask

    // Two chained descriptors, card to memory, unaligned buffer
    task automatic t_read_chain();
        int l0, d0, s0;
        put_desc(32'h200, 32'h8000_0018, 32'd8, 32'h602, 32'h240);
        put_desc(32'h240, 32'h8000_0014, 32'd12, 32'h700, 32'h0);
        poke(32'h608, 32'h5555_5555);
        l0 = log_n; d0 = done_cnt; s0 = rx_seq;
        kick(1'b0, 32'd20, 32'h200);
        wait_done(d0);
        check("R5 aligned word0", mem[32'h600 >> 2], 32'hC0DE_0000 + 32'(s0));
        check("R5 aligned word1", mem[32'h604 >> 2], 32'hC0DE_0000 + 32'(s0 + 1));
        check("R4 buffer bound", mem[32'h608 >> 2], 32'h5555_5555);
        for (int i = 0; i < 3; i++)
            check("R8 rx to mem", mem[(32'h700 >> 2) + i], 32'hC0DE_0000 + 32'(s0 + 2 + i));
        check("R6 writeback A", mem[32'h200 >> 2], 32'h0000_0018);
        check("R6 writeback B", mem[32'h240 >> 2], 32'h0000_0014);
        check_fetch("R7 follow next", l0 + 7, 32'h240);
        check("R11 access total", 32'(log_n - l0), 15);
        check("R9 flags read, tx cleared", {27'd0, data_complete, sdio_irq, dma_summary, tx_done, rx_done}, 32'b11101);
        check("R10 remaining", remaining, 0);
    endtask

    // Clamping of oversize and zero sizes
    task automatic t_clamp();
        int l0, t0, d0;
        put_desc(32'h300, 32'h8000_0010, 32'd100, 32'h800, 32'h340);
        put_desc(32'h340, 32'h8000_0004, 32'd0, 32'h900, 32'h0);
        for (int i = 0; i < 8; i++) poke(32'h800 + 32'(4 * i), 32'h2000_0000 + 32'(i));
        for (int i = 0; i < 4; i++) poke(32'h900 + 32'(4 * i), 32'h3000_0000 + 32'(i));
        l0 = log_n; t0 = tx_n; d0 = done_cnt;
        kick(1'b1, 32'd48, 32'h300);
        wait_done(d0);
        check("R3 clamp total words", 32'(tx_n - t0), 12);
        for (int i = 0; i < 8; i++) check("R3 oversize clamped", tx_log[t0 + i], 32'h2000_0000 + 32'(i));
        for (int i = 0; i < 4; i++) check("R4 zero size min remaining", tx_log[t0 + 8 + i], 32'h3000_0000 + 32'(i));
        check_fetch("R7 second fetch", l0 + 13, 32'h340);
        check("R10 remaining", remaining, 0);
    endtask

    // Count reaches zero without a last flag
    task automatic t_count_stop();
        int l0, t0, d0;
        put_desc(32'h380, 32'h8000_0000, 32'd16, 32'hA00, 32'hF00);
        poke(32'hA00, 32'hAAAA_0001); poke(32'hA04, 32'hAAAA_0002);
        l0 = log_n; t0 = tx_n; d0 = done_cnt;
        kick(1'b1, 32'd8, 32'h380);
        wait_done(d0);
        check("R7 stop on zero count", 32'(log_n - l0), 7);
        check("R4 min of size and count", 32'(tx_n - t0), 2);
        check("R8 tx data", tx_log[t0 + 1], 32'hAAAA_0002);
        check("R6 writeback", mem[32'h380 >> 2], 32'h0);
        check("R9 done", 32'(done_cnt - d0), 1);
    endtask

    // Last flag ends the chain with count left over
    task automatic t_last_stop();
        int l0, d0, s0;
        put_desc(32'h3C0, 32'h8000_0004, 32'd8, 32'hB00, 32'h3C0);
        l0 = log_n; d0 = done_cnt; s0 = rx_seq;
        kick(1'b0, 32'd64, 32'h3C0);
        wait_done(d0);
        check("R7 stop on last", 32'(log_n - l0), 7);
        check("R10 remaining after last", remaining, 32'd56);
        check("R8 rx word", mem[32'hB04 >> 2], 32'hC0DE_0000 + 32'(s0 + 1));
        check("R9 flags read", {27'd0, sdio_irq, dma_summary, tx_done, rx_done}, 32'b1101);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gate();
        t_write_single();
        t_read_chain();
        t_clamp();
        t_count_stop();
        t_last_stop();
        repeat (5) @(negedge clk);
        summary();
    end
endmodule